// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Sequencer

This block sits beside a processor's bus controller and turns external interrupt pins into a vector for the core. It takes two kinds of request. The first is a maskable request, which is level-sensitive and is honoured only while the core's interrupt-enable flag is set. The second is a non-maskable request, which is detected on its rising edge. The block also filters the raw reset pin, so that only a long enough assertion resets the block.

A maskable request makes the block ask the bus controller for two back-to-back interrupt-acknowledge cycles. The bus lock is held from the start of the first cycle to the end of the second. The vector byte that is present on the low data lines when the second cycle completes becomes the interrupt number. A non-maskable request needs no bus traffic and always yields slot 2. After one is taken, further ones wait until the core signals a return from the handler. At most one edge that arrives during that wait is kept and served once the return arrives.

The block runs on the fast input clock. Its decisions are made only on every second edge, which follows the core's half-rate clock. The `tick` output marks those edges.

Top module: `irq_ack_seq`

## Requirements
- R1: The maskable request starts acknowledge traffic only while `int_en` is high at a decision edge; with `int_en` low, a request held high for any length of time causes no bus cycle and no vector.
- R2: An accepted maskable request produces exactly two acknowledge cycles, each ended by `bus_done`; the value of `bus_data[7:0]` when the second one completes is reported as `vec_num` with `vec_nmi` low.
- R3: While acknowledging, `bus_code` (bit order {memory/IO, data/code, write/read}) is 3'b000 and `bus_lock` is high; the lock and request stay asserted without a gap from the start of the first cycle until the second cycle completes, otherwise `bus_code` is 3'b001.
- R4: A rising edge of `nmi` produces a vector of 2 with `vec_nmi` high; a level that stays high produces no further vectors.
- R5: A non-maskable request produces no acknowledge bus cycle.
- R6: After a non-maskable request is taken, further edges are not served until a pulse on `iret_in`; one edge that arrives while blocked is kept and served right after the return, and any further edges during the same wait are dropped.
- R7: When a non-maskable edge and an enabled maskable request are seen at the same decision edge, the non-maskable vector is reported first and the maskable sequence follows.
- R8: `reset_taken` goes high on the 15th consecutive input-clock edge at which `rst_in` is high, and not before; a shorter pulse changes no state.
- R9: While `reset_taken` is high, all other inputs are ignored, no bus request or vector is produced, and the non-maskable block is cleared.
- R10: Outside reset, `tick` alternates on every input-clock edge, and state changes only on edges where `tick` was high.
- R11: `vec_valid` is high for exactly one input-clock cycle per reported vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, twice the core rate |
| rst_in | input | 1 | Raw reset pin, active high |
| int_en | input | 1 | Core interrupt-enable flag |
| intr | input | 1 | Maskable request, level-sensitive |
| nmi | input | 1 | Non-maskable request, rising-edge |
| iret_in | input | 1 | Return-from-handler indication |
| bus_done | input | 1 | Current acknowledge bus cycle has completed |
| bus_data | input | 8 | Low data lines carrying the vector |
| tick | output | 1 | High on the half-rate edges where decisions occur |
| reset_taken | output | 1 | Qualified reset is active |
| ack_req | output | 1 | Request to run an acknowledge bus cycle |
| bus_lock | output | 1 | Bus lock during acknowledge |
| bus_code | output | 3 | Cycle type {memory/IO, data/code, write/read} |
| vec_valid | output | 1 | One-cycle strobe: vector available |
| vec_num | output | 8 | Interrupt number |
| vec_nmi | output | 1 | High when the vector came from the non-maskable path |

## Verification
On every cycle, the assertions check several properties: the half-rate tick, the single-cycle vector strobe, the fixed slot and absence of bus traffic on the non-maskable path, that acknowledge traffic starts only from an enabled request, that the lock is released only on a completed cycle, and that reset leaves the bus idle. Only the bench scenarios can show the behaviours that depend on history. These are the value of the captured vector across all 256 byte values, that an edge held while blocked is served after the return but a second one is not, the ordering when both requests coincide, and the exact 15-edge qualification with a 14-edge pulse leaving the block untouched.

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int RST_MIN  = 15,
  parameter int VEC_W    = 8,
  parameter int NMI_SLOT = 2
) (
  input  logic             clk,
  input  logic             rst_in,
  input  logic             int_en,
  input  logic             intr,
  input  logic             nmi,
  input  logic             iret_in,
  input  logic             bus_done,
  input  logic [VEC_W-1:0] bus_data,
  output logic             tick,
  output logic             reset_taken,
  output logic             ack_req,
  output logic             bus_lock,
  output logic [2:0]       bus_code,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_num,
  output logic             vec_nmi
);

  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [2:0] CODE_ACK  = 3'b000;
  localparam logic [2:0] CODE_IDLE = 3'b001;

  typedef enum logic [1:0] {S_IDLE, S_ACK1, S_ACK2} st_t;

  st_t         state;
  logic [CW-1:0] rcnt;
  logic        nmi_q, nmi_blk, nmi_pend;
  logic        en, nmi_edge, take_nmi, take_int, int_fin;

  always_ff @(posedge clk)
    if (!rst_in)                   rcnt <= '0;
    else if (rcnt != CW'(RST_MIN)) rcnt <= rcnt + 1'b1;

  assign reset_taken = rst_in && (rcnt == CW'(RST_MIN));

  always_ff @(posedge clk)
    if (reset_taken) tick <= 1'b0;
    else             tick <= ~tick;

  assign en       = tick;
  assign nmi_edge = nmi && !nmi_q;
  assign take_nmi = (state == S_IDLE) && !nmi_blk && (nmi_edge || nmi_pend);
  assign take_int = (state == S_IDLE) && !take_nmi && intr && int_en;
  assign int_fin  = (state == S_ACK2) && bus_done;

  always_ff @(posedge clk) begin
    if (reset_taken) begin
      state    <= S_IDLE;
      nmi_q    <= nmi;
      nmi_blk  <= 1'b0;
      nmi_pend <= 1'b0;
      vec_num  <= '0;
      vec_nmi  <= 1'b0;
    end else if (en) begin
      nmi_q <= nmi;
      if (take_nmi)     nmi_blk <= 1'b1;
      else if (iret_in) nmi_blk <= 1'b0;
      if (take_nmi)
        nmi_pend <= 1'b0;
      else if (nmi_edge && (nmi_blk || state != S_IDLE))
        nmi_pend <= 1'b1;
      case (state)
        S_IDLE: if (take_int) state <= S_ACK1;
        S_ACK1: if (bus_done) state <= S_ACK2;
        S_ACK2: if (bus_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (take_nmi) begin
        vec_num <= VEC_W'(NMI_SLOT);
        vec_nmi <= 1'b1;
      end else if (int_fin) begin
        vec_num <= bus_data;
        vec_nmi <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk)
    if (reset_taken) vec_valid <= 1'b0;
    else             vec_valid <= en && (take_nmi || int_fin);

  assign ack_req  = (state != S_IDLE);
  assign bus_lock = ack_req;
  assign bus_code = ack_req ? CODE_ACK : CODE_IDLE;

  AST_INT_GATED: assert property (@(posedge clk) disable iff (reset_taken)
    $rose(ack_req) |-> $past(intr && int_en)); // R1
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (reset_taken)
    $fell(ack_req) |-> ($past(bus_done) || $past(reset_taken))); // R3
  AST_NMI_SLOT: assert property (@(posedge clk) disable iff (reset_taken)
    (vec_valid && vec_nmi) |-> (vec_num == VEC_W'(NMI_SLOT))); // R4
  AST_NMI_NO_BUS: assert property (@(posedge clk) disable iff (reset_taken)
    (vec_valid && vec_nmi) |-> !ack_req); // R5
  AST_NMI_UNBLOCKED: assert property (@(posedge clk) disable iff (reset_taken)
    (vec_valid && vec_nmi) |-> !$past(nmi_blk)); // R6
  AST_RST_IDLE: assert property (@(posedge clk)
    reset_taken |=> (!ack_req && !vec_valid)); // R9
  AST_TICK_RISE: assert property (@(posedge clk) disable iff (reset_taken)
    !tick |=> tick); // R10
  AST_TICK_FALL: assert property (@(posedge clk) disable iff (reset_taken)
    tick |=> !tick); // R10
  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (reset_taken)
    vec_valid |=> !vec_valid); // R11

endmodule

// File: tb/irq_ack_seq_test.sv
module irq_ack_seq_test;

  logic       clk = 1'b0;
  logic       rst_in = 1'b1, int_en = 1'b0, intr = 1'b0, nmi = 1'b0, iret_in = 1'b0;
  logic       bus_done = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic       tick, reset_taken, ack_req, bus_lock, vec_valid, vec_nmi;
  logic [2:0] bus_code;
  logic [7:0] vec_num;

  int checks = 0, failures = 0;
  int nvec = 0, nack = 0, nrst = 0, code_bad = 0, pulse_bad = 0, tick_bad = 0;
  int last_num = -1, last_nmi = -1;
  bit prev_vv = 0, prev_ack = 0, prev_rt = 1, prev_tick = 0, finished = 0;

  always #10 clk = ~clk;

  irq_ack_seq uut (
    .clk(clk), .rst_in(rst_in), .int_en(int_en), .intr(intr), .nmi(nmi),
    .iret_in(iret_in), .bus_done(bus_done), .bus_data(bus_data),
    .tick(tick), .reset_taken(reset_taken), .ack_req(ack_req), .bus_lock(bus_lock),
    .bus_code(bus_code), .vec_valid(vec_valid), .vec_num(vec_num), .vec_nmi(vec_nmi)
  );

  always @(negedge clk) begin
    if (vec_valid) begin
      nvec++;
      last_num = int'(vec_num);
      last_nmi = int'(vec_nmi);
      if (prev_vv) pulse_bad++;
    end
    prev_vv = vec_valid;
    if (ack_req && !prev_ack) nack++;
    prev_ack = ack_req;
    if (ack_req && (bus_code != 3'b000 || !bus_lock)) code_bad++;
    if (!ack_req && bus_code != 3'b001) code_bad++;
    if (reset_taken) nrst++;
    if (!reset_taken && !prev_rt && tick == prev_tick) tick_bad++;
    prev_tick = tick;
    prev_rt = reset_taken;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ack();
    for (int k = 0; k < 50 && !ack_req; k++) step(1);
  endtask

  task automatic respond(input logic [7:0] d);
    wait_ack();
    step(2);
    bus_done = 1'b1; bus_data = 8'hFF;
    step(2);
    bus_done = 1'b0;
    step(2);
    bus_done = 1'b1; bus_data = d;
    step(2);
    bus_done = 1'b0; bus_data = 8'h00;
    step(3);
  endtask

  task automatic nmi_pulse();
    nmi = 1'b1; step(4);
    nmi = 1'b0; step(4);
  endtask

  task automatic iret_pulse();
    iret_in = 1'b1; step(2);
    iret_in = 1'b0; step(4);
  endtask

  task automatic run_intr(input int d);
    int n0, a0;
    n0 = nvec; a0 = nack;
    intr = 1'b1;
    wait_ack();
    intr = 1'b0;
    respond(8'(d));
    chk(nvec == n0 + 1, "R2 vector count", nvec, n0 + 1);
    chk(last_num == d, "R2 vector value", last_num, d);
    chk(last_nmi == 0, "R2 maskable flag", last_nmi, 0);
    chk(nack == a0 + 1, "R3 lock span single", nack, a0 + 1);
    chk(ack_req == 1'b0, "R2 bus released", int'(ack_req), 0);
  endtask

  initial begin
    int n0, a0, r0;
    step(20);
    chk(reset_taken == 1'b1, "R8 power-up reset", int'(reset_taken), 1);
    chk(!ack_req && !vec_valid, "R9 idle in reset", int'(ack_req), 0);
    chk(bus_code == 3'b001, "R3 idle code", int'(bus_code), 1);
    rst_in = 1'b0;
    step(3);

    intr = 1'b1;
    step(40);
    chk(nack == 0, "R1 masked no ack", nack, 0);
    chk(nvec == 0, "R1 masked no vector", nvec, 0);
    intr = 1'b0;
    int_en = 1'b1;
    step(2);

    for (int d = 0; d < 256; d++) run_intr(d);

    n0 = nvec; a0 = nack;
    nmi_pulse();
    chk(nvec == n0 + 1, "R4 nmi taken", nvec, n0 + 1);
    chk(last_num == 2, "R4 nmi slot", last_num, 2);
    chk(last_nmi == 1, "R4 nmi flag", last_nmi, 1);
    chk(nack == a0, "R5 nmi no bus", nack, a0);

    n0 = nvec;
    nmi_pulse();
    chk(nvec == n0, "R6 blocked", nvec, n0);
    iret_pulse();
    chk(nvec == n0 + 1, "R6 pending served", nvec, n0 + 1);
    chk(last_nmi == 1 && last_num == 2, "R6 pending vector", last_num, 2);

    n0 = nvec;
    iret_pulse();
    chk(nvec == n0, "R6 return alone", nvec, n0);
    nmi = 1'b1; step(4);
    chk(nvec == n0 + 1, "R4 edge taken", nvec, n0 + 1);
    iret_pulse();
    step(10);
    chk(nvec == n0 + 1, "R4 level no retrigger", nvec, n0 + 1);
    nmi = 1'b0; step(4);

    n0 = nvec;
    nmi_pulse();
    nmi_pulse();
    nmi_pulse();
    chk(nvec == n0 + 1, "R6 one taken", nvec, n0 + 1);
    iret_pulse();
    step(20);
    chk(nvec == n0 + 2, "R6 only one kept", nvec, n0 + 2);

    iret_pulse();
    n0 = nvec; a0 = nack;
    intr = 1'b1; nmi = 1'b1;
    step(3);
    chk(nvec == n0 + 1 && last_nmi == 1, "R7 nmi first", last_nmi, 1);
    wait_ack();
    intr = 1'b0;
    respond(8'hA5);
    chk(nvec == n0 + 2 && last_num == 8'hA5, "R7 maskable after", last_num, 8'hA5);
    chk(nack == a0 + 1, "R7 one ack sequence", nack, a0 + 1);
    nmi = 1'b0; step(4);

    r0 = nrst;
    rst_in = 1'b1; step(14);
    chk(reset_taken == 1'b0, "R8 fourteen edges", int'(reset_taken), 0);
    rst_in = 1'b0; step(2);
    chk(nrst == r0, "R8 short pulse", nrst, r0);
    n0 = nvec;
    nmi_pulse();
    chk(nvec == n0, "R8 state kept", nvec, n0);

    rst_in = 1'b1; step(15);
    chk(reset_taken == 1'b1, "R8 fifteen edges", int'(reset_taken), 1);
    n0 = nvec; a0 = nack;
    intr = 1'b1; nmi = 1'b1; iret_in = 1'b1; step(5);
    nmi = 1'b0; step(3); nmi = 1'b1; step(3);
    chk(ack_req == 1'b0 && vec_valid == 1'b0, "R9 outputs idle", int'(ack_req), 0);
    intr = 1'b0; nmi = 1'b0; iret_in = 1'b0; step(2);
    rst_in = 1'b0; step(6);
    chk(nvec == n0, "R9 no vector", nvec, n0);
    chk(nack == a0, "R9 no ack", nack, a0);
    nmi_pulse();
    chk(nvec == n0 + 1 && last_nmi == 1, "R9 block cleared", nvec, n0 + 1);

    chk(code_bad == 0, "R3 cycle code and lock", code_bad, 0);
    chk(pulse_bad == 0, "R11 single-cycle strobe", pulse_bad, 0);
    chk(tick_bad == 0, "R10 half-rate tick", tick_bad, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule